// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned N-bit operands and presents the full 2N-bit product. It is purely combinational: there is no clock, no reset and no handshake. The product follows the operands after the propagation delay of the gate tree.

The design is built as a tree. The smallest unit is a 2x2 cell made of four AND gates and two half adders. Above it, each merge stage takes four sub-products of half width and combines them. The sub-products are low-by-low, high-a-by-low-b, low-a-by-high-b and high-by-high. They are joined through a fixed arrangement:

- The upper half of the low-by-low result is joined with the lower half of the high-by-high result.
- That joined word goes into a 3:2 carry-save layer together with the two cross sub-products.
- A short carry-propagate adder folds the sum and carry vectors.
- A tiny top adder adds the spill-over of the short adder to the upper half of the high-by-high result.

The same merge stage is reused at every level, so the 8x8 multiplier is built from four 4x4 multipliers, and each 4x4 multiplier from four 2x2 cells.

Top module: `vcx_mult`

## Requirements
- R1: For every pair of unsigned operands `op_a`, `op_b`, `prod` equals the arithmetic product `op_a * op_b`, with no bit lost.
- R2: Product bit 0 equals `op_a[0] & op_b[0]`, and the lowest two product bits equal the low two bits of the product of the low 2-bit slices of the operands.
- R3: When either operand is zero, `prod` is zero regardless of the other operand.
- R4: When either operand is one, `prod` equals the other operand, zero-extended to 2N bits.
- R5: Swapping the operands leaves `prod` unchanged.
- R6: With both operands at all ones, `prod` equals 2^(2N) - 2^(N+1) + 1, for example 16'hFE01 at N=8.
- R7: Product bit 2N-1 can be set only when bit N-1 of both operands is set.
- R8: When one operand is a power of two 2^k, `prod` equals the other operand shifted left by k.
- R9: The output is a function of the present operands only: a new operand pair is reflected on `prod` without any clock edge.
- R10: The parameter N may be any power of two from 2 upward. The same cell and merge structure produces a correct product at N=2, N=4 and N=8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product of `op_a` and `op_b` |

## Verification
A short table of hand-computed pairs comes first. It covers zero, unity, all-ones, a single top bit, and nibble patterns that load only the cross sub-products or only the diagonal ones. Each of these points at a specific path: the two diagonal slices, the carry-save layer, or the top spill adder. Every operand pair of the 8-bit and 4-bit widths is then compared against an independent multiply. This exhaustive sweep separates a wrong bit placement in the joined word or a dropped carry shift, which hit only some operand combinations. The 2-bit instance shows that the bare cell works without any merge stage. Swapped operands, power-of-two operands and the top-bit rule are checked on the sweep as well.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

    // Bits occupied by all nodes of tree level lvl (level 1 = 2x2 cells).
    function automatic int lvl_bits(input int lvl, input int levels);
        return 1 << (2 * levels - lvl + 1);
    endfunction

    // Start bit of tree level lvl inside the flat tree vector.
    function automatic int lvl_base(input int lvl, input int levels);
        int acc;
        acc = 0;
        for (int j = 1; j < lvl; j++) begin
            acc += lvl_bits(j, levels);
        end
        return acc;
    endfunction

    // Operand bit offset of 2x2 cell k. sel=0 gives the op_a offset,
    // sel=1 gives the op_b offset. Quadrant code per base-4 digit:
    // 0 lo*lo, 1 hi_a*lo_b, 2 lo_a*hi_b, 3 hi*hi.
    function automatic int leaf_off(input int k, input int levels, input int sel);
        int acc;
        int dig;
        acc = 0;
        for (int j = 0; j < levels - 1; j++) begin
            dig = (k >> (2 * j)) & 3;
            acc += ((dig >> sel) & 1) << (j + 1);
        end
        return acc;
    endfunction

endpackage

// File: rtl/vcx_cell2.sv
module vcx_cell2 (
    input  logic [1:0] x,
    input  logic [1:0] y,
    output logic [3:0] pp
);
    logic t00, t10, t01, t11;
    logic ha0_s, ha0_c, ha1_s, ha1_c;

    always_comb begin
        t00   = x[0] & y[0];
        t10   = x[1] & y[0];
        t01   = x[0] & y[1];
        t11   = x[1] & y[1];
        // first half adder: crosswise terms
        ha0_s = t10 ^ t01;
        ha0_c = t10 & t01;
        // second half adder: vertical high term plus carry
        ha1_s = t11 ^ ha0_c;
        ha1_c = t11 & ha0_c;
        pp    = {ha1_c, ha1_s, ha0_s, t00};
    end
endmodule

// File: rtl/vcx_csa.sv
module vcx_csa #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    for (genvar i = 0; i < W; i++) begin : g_fa
        always_comb begin
            s[i] = x[i] ^ y[i] ^ z[i];
            c[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
        end
    end
endmodule

// File: rtl/vcx_merge.sv
module vcx_merge #(
    parameter int H = 2
) (
    input  logic [2*H-1:0] ll,
    input  logic [2*H-1:0] hl,
    input  logic [2*H-1:0] lh,
    input  logic [2*H-1:0] hh,
    output logic [4*H-1:0] prod
);
    localparam int PW = 2 * H;
    localparam int MW = PW + 2;

    logic [PW-1:0] join_w;
    logic [PW-1:0] sum_v;
    logic [PW-1:0] car_v;
    logic [MW-1:0] mid_d;
    logic [H-1:0]  top_d;

    // upper half of lo*lo joined under lower half of hi*hi
    assign join_w = {hh[H-1:0], ll[PW-1:H]};

    vcx_csa #(.W(PW)) u_csa (
        .x (join_w),
        .y (hl),
        .z (lh),
        .s (sum_v),
        .c (car_v)
    );

    always_comb begin
        mid_d = {2'b00, sum_v} + {1'b0, car_v, 1'b0};
        top_d = hh[PW-1:H] + H'(mid_d[MW-1:PW]);
    end

    assign prod = {top_d, mid_d[PW-1:0], ll[H-1:0]};
endmodule

// File: rtl/vcx_mult.sv
module vcx_mult #(
    parameter int N = 8
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] prod
);
    localparam int LEVELS = $clog2(N);
    localparam int LEAVES = 1 << (2 * (LEVELS - 1));
    localparam int TOTAL  = vcx_pkg::lvl_base(LEVELS + 1, LEVELS);
    localparam int ROOT   = vcx_pkg::lvl_base(LEVELS, LEVELS);

    logic [TOTAL-1:0] tree;

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        localparam int AO = vcx_pkg::leaf_off(k, LEVELS, 0);
        localparam int BO = vcx_pkg::leaf_off(k, LEVELS, 1);
        vcx_cell2 u_cell (
            .x  (op_a[AO +: 2]),
            .y  (op_b[BO +: 2]),
            .pp (tree[k*4 +: 4])
        );
    end

    for (genvar l = 2; l <= LEVELS; l++) begin : g_lvl
        localparam int H     = 1 << (l - 1);
        localparam int CW    = 2 * H;
        localparam int NW    = 4 * H;
        localparam int NODES = 1 << (2 * (LEVELS - l));
        localparam int CB    = vcx_pkg::lvl_base(l - 1, LEVELS);
        localparam int OB    = vcx_pkg::lvl_base(l, LEVELS);
        for (genvar m = 0; m < NODES; m++) begin : g_node
            vcx_merge #(.H(H)) u_merge (
                .ll   (tree[CB + (4*m+0)*CW +: CW]),
                .hl   (tree[CB + (4*m+1)*CW +: CW]),
                .lh   (tree[CB + (4*m+2)*CW +: CW]),
                .hh   (tree[CB + (4*m+3)*CW +: CW]),
                .prod (tree[OB + m*NW +: NW])
            );
        end
    end

    assign prod = tree[ROOT +: 2*N];
endmodule

// File: rtl/vcx_mult_chk.sv
module vcx_mult_chk #(
    parameter int N = 8
) (
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [2*N-1:0] prod
);
    logic [2*N-1:0] ref_p;
    logic [1:0]     lo_ref;

    always_comb begin
        ref_p  = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
        lo_ref = 2'({2'b00, op_a[1:0]} * {2'b00, op_b[1:0]});
        p_exact_r1: assert (prod == ref_p)
            else $error("R1 product %h for %h*%h", prod, op_a, op_b);
        p_low_pair_r2: assert (prod[1:0] == lo_ref)
            else $error("R2 low bits %b", prod[1:0]);
        if (op_a == '0 || op_b == '0) begin
            p_zero_r3: assert (prod == '0)
                else $error("R3 nonzero product %h", prod);
        end
        if (op_b == N'(1)) begin
            p_unit_r4: assert (prod == {{N{1'b0}}, op_a})
                else $error("R4 unit product %h", prod);
        end
        if (prod[2*N-1]) begin
            p_topbit_r7: assert (op_a[N-1] && op_b[N-1])
                else $error("R7 top bit with %h %h", op_a, op_b);
        end
    end
endmodule

bind vcx_mult vcx_mult_chk #(.N(N)) u_chk (
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
);

// File: tb/vcx_mult_tb_top.sv
module vcx_mult_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] p8;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;
    logic [1:0]  a2 = '0, b2 = '0;
    logic [3:0]  p2;

    vcx_mult #(.N(8)) dut_i  (.op_a(a8), .op_b(b8), .prod(p8));
    vcx_mult #(.N(4)) dut4_i (.op_a(a4), .op_b(b4), .prod(p4));
    vcx_mult #(.N(2)) dut2_i (.op_a(a2), .op_b(b2), .prod(p2));

    // {a, b, expected product}
    localparam logic [31:0] VEC [13] = '{
        {8'h00, 8'h00, 16'h0000},
        {8'h00, 8'hFF, 16'h0000},
        {8'hFF, 8'h01, 16'h00FF},
        {8'h01, 8'hB7, 16'h00B7},
        {8'hFF, 8'hFF, 16'hFE01},
        {8'h80, 8'h80, 16'h4000},
        {8'h0F, 8'h0F, 16'h00E1},
        {8'hF0, 8'h0F, 16'h0E10},
        {8'h0F, 8'hF0, 16'h0E10},
        {8'hAA, 8'h55, 16'h3872},
        {8'h12, 8'h34, 16'h03A8},
        {8'hC8, 8'h02, 16'h0190},
        {8'h80, 8'hFF, 16'h7F80}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            bad++;
            $display("FAIL watchdog R9 actual=%0d expected<150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        @(negedge clk); #1;
        check("R3 idle zero operands", p8, 16'h0000);

        // table of directed pairs (R1, R3, R4, R6, R8)
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            a8 = VEC[i][31:24];
            b8 = VEC[i][23:16];
            #1;
            check("R1 table vector", p8, VEC[i][15:0]);
        end

        // R9: change operands mid-cycle, no edge in between
        @(posedge clk); #0.5;
        a8 = 8'h0D; b8 = 8'h0B; #0.5;
        check("R9 no clock needed", p8, 16'd143);
        a8 = 8'hFE; #0.5;
        check("R9 second change", p8, 16'd2794);

        // exhaustive 8-bit sweep: R1, R2, R5, R7, R8
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [15:0] e;
                logic [15:0] sw;
                @(negedge clk);
                e  = 16'(x * y);
                b8 = 8'(x); a8 = 8'(y); #0.5;
                sw = p8;
                a8 = 8'(x); b8 = 8'(y); #0.5;
                check("R1 exhaustive 8", p8, e);
                if (sw !== p8) check("R5 swapped operands", sw, p8);
                if (p8[0] !== (a8[0] & b8[0])) check("R2 bit0", {15'd0, p8[0]}, {15'd0, a8[0] & b8[0]});
                if (p8[15] && !(a8[7] && b8[7])) check("R7 top bit", {15'd0, p8[15]}, 16'd0);
                if ((y & (y - 1)) == 0 && y != 0) check("R8 power of two", p8, 16'(x << $clog2(y)));
            end
        end
        check("R6 all ones 8", 16'(255 * 255), 16'hFE01);

        // R10: other widths
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                @(negedge clk);
                a4 = 4'(x); b4 = 4'(y); #1;
                check("R10 exhaustive 4", {8'd0, p4}, 16'(x * y));
            end
        end
        @(negedge clk); a4 = 4'hF; b4 = 4'hF; #1;
        check("R6 all ones 4", {8'd0, p4}, 16'h00E1);
        for (int x = 0; x < 4; x++) begin
            for (int y = 0; y < 4; y++) begin
                @(negedge clk);
                a2 = 2'(x); b2 = 2'(y); #1;
                check("R10 exhaustive 2", {12'd0, p2}, 16'(x * y));
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule